// File: doc/BRIEF.md
# SDRAM Geometry Probe Engine

This block is a bus master that works out how many column, bank and row address bits an attached memory really decodes. Address bits that the device does not decode fold back onto lower locations. The engine uses this folding: for each candidate width it stores zero at a base address and a marker word at a power-of-two offset above the base. It then reads both locations back. If the marker is at the offset and the base still holds zero, the address bit under test is real.

Software or an init sequencer supplies the largest widths the address map allows and the memory type code, then pulses `start`. The engine first searches the column width, then settles the bank width, then searches the row width. It reports the three widths, the capacity as a power-of-two byte exponent and a packed status word, or it raises an error flag when no usable column or row width is found. All accesses go through a single word port with a valid/ready request and a separate read-data strobe. The bus-width exponent is a parameter (1 for a 16-bit bus).

Top module: `geom_probe`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `row12` and `mem_valid` are low, and `status` and `size_log2` are zero.
- R2: Each probe for an offset exponent e makes four accesses in this order: a write of 0 to BASE, a write of PATTERN to BASE + 2^e, a read of BASE + 2^e, and a read of BASE. The probe passes when the first read returns PATTERN and the second returns 0. A request holds its address, write enable and write data stable while `mem_valid` is high and `mem_ready` is low.
- R3: Column widths are tried from `col_max` down to 10 with e = c + BW - 1, and the first passing width is reported in `col_w`.
- R4: If no column width of 10 or more passes (including `col_max` below 10), `err` rises, `done` stays low, and no bank or row access is made.
- R5: When `mem_type` is 3, `bank_w` is 3 and no bank probe is made. For any other type, one probe at e = bank_max + col_max + BW - 1 gives `bank_w` = 3 on a pass and 2 on a fail.
- R6: Row widths are tried from `row_max` down to 12 with e = r + bank_max + col_max + BW - 1, and the first passing width is reported in `row_w`.
- R7: If no row width of 12 or more passes, `err` rises and `done` stays low.
- R8: While `done` is high, `size_log2` equals BW + col_w + row_w + bank_w, the log2 of the capacity in bytes.
- R9: While `done` is high, `status` holds col_w-9 in bits [3:0], a bank code in bit [4] (0 for 8 banks, 1 for 4 banks), row_w-13 modulo 16 in bits [8:5] and the memory type in bits [11:9]. Bits [15:12] are zero. When `done` is low, `status` is zero.
- R10: `row12` is high exactly when `done` is high and `row_w` is 12.
- R11: `busy` is high from the cycle after an accepted `start` until `done` or `err` rises, and it is never high together with either of them. A `start` pulse while `busy` is high is ignored, and no request is made while `busy` is low.
- R12: Results, `done` and `err` hold unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe run (ignored while busy) |
| mem_type | input | 3 | Memory type code; 3 fixes 8 banks |
| col_max | input | WW | Largest column width to try |
| bank_max | input | BKW | Bank width in the address map |
| row_max | input | WW | Largest row width to try |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished with a valid geometry |
| err | output | 1 | Run failed to find a column or row width |
| col_w | output | WW | Detected column width |
| bank_w | output | BKW | Detected bank width |
| row_w | output | WW | Detected row width |
| size_log2 | output | 7 | Capacity exponent in bytes |
| status | output | 16 | Packed result word |
| row12 | output | 1 | Row width is 12 |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |

## Verification
The bench attaches a memory that folds undecoded column, bank and row bits, and it stalls `mem_ready` one cycle in three. It targets a column width below the maximum, a memory type that must skip the bank probe even though its real bank count is smaller, a row width of exactly 12 (where the row-13 field wraps and the extra flag is set), errors in the column search and in the row search, a `col_max` below the lower limit, and a second `start` pulse in the middle of a run. A design that probed the wrong offset would report a wider or narrower width. One that ignored the type would probe and return 4 banks. One that let the search continue past its lower limit would make extra accesses or report a width under 10 or 12. One that honoured the second pulse would return the second run's geometry.

// File: rtl/geom_pkg.sv
package geom_pkg;
  typedef enum logic [2:0] {
    PU_IDLE, PU_WZERO, PU_WPAT, PU_RPAT, PU_RPAT_W, PU_RBASE, PU_RBASE_W
  } pu_state_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_COL, SQ_BANK, SQ_ROW, SQ_DONE, SQ_FAIL
  } sq_state_t;

  localparam int COL_FLOOR = 10;
  localparam int ROW_FLOOR = 12;
  localparam logic [2:0] TYPE_FIXED_8BANK = 3'd3;
endpackage

// File: rtl/geom_rst_sync.sv
module geom_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_sync_n = sr_q[1];
endmodule

// File: rtl/geom_access.sv
module geom_access
  import geom_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int EW = 6,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [DW-1:0] PATTERN = 32'h5AA5_C33C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [EW-1:0] exp_i,
  output logic          fin,
  output logic          pass,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  pu_state_t     st_q, st_d;
  logic [AW-1:0] off_q, off_d;
  logic          hit_q, hit_d;
  logic          off_en, hit_en;

  always_comb begin
    st_d   = st_q;
    off_d  = off_q;
    hit_d  = hit_q;
    off_en = 1'b0;
    hit_en = 1'b0;
    fin    = 1'b0;
    pass   = 1'b0;
    case (st_q)
      PU_IDLE: if (go) begin
        off_d  = AW'(1) << exp_i;
        off_en = 1'b1;
        st_d   = PU_WZERO;
      end
      PU_WZERO:  if (mem_ready) st_d = PU_WPAT;
      PU_WPAT:   if (mem_ready) st_d = PU_RPAT;
      PU_RPAT:   if (mem_ready) st_d = PU_RPAT_W;
      PU_RPAT_W: if (mem_rvalid) begin
        hit_d  = (mem_rdata == PATTERN);
        hit_en = 1'b1;
        st_d   = PU_RBASE;
      end
      PU_RBASE:  if (mem_ready) st_d = PU_RBASE_W;
      PU_RBASE_W: if (mem_rvalid) begin
        fin  = 1'b1;
        pass = hit_q && (mem_rdata == '0);
        st_d = PU_IDLE;
      end
      default: st_d = PU_IDLE;
    endcase
  end

  always_comb begin
    mem_valid = (st_q == PU_WZERO) || (st_q == PU_WPAT) ||
                (st_q == PU_RPAT)  || (st_q == PU_RBASE);
    mem_we    = (st_q == PU_WZERO) || (st_q == PU_WPAT);
    mem_addr  = ((st_q == PU_WPAT) || (st_q == PU_RPAT)) ? (BASE + off_q) : BASE;
    mem_wdata = (st_q == PU_WPAT) ? PATTERN : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PU_IDLE;
      off_q <= '0;
      hit_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (off_en) off_q <= off_d;
      if (hit_en) hit_q <= hit_d;
    end
  end
endmodule

// File: rtl/geom_seq.sv
module geom_seq
  import geom_pkg::*;
#(
  parameter int WW  = 5,
  parameter int BKW = 2,
  parameter int EW  = 6,
  parameter int BW  = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     mem_type,
  input  logic [WW-1:0]  col_max,
  input  logic [BKW-1:0] bank_max,
  input  logic [WW-1:0]  row_max,
  input  logic           fin,
  input  logic           pass,
  output logic           go,
  output logic [EW-1:0]  exp_o,
  output logic           busy,
  output logic           done,
  output logic           fail,
  output logic [WW-1:0]  col_w,
  output logic [BKW-1:0] bank_w,
  output logic [WW-1:0]  row_w,
  output logic [2:0]     type_o
);
  localparam logic [WW-1:0]  CMIN = WW'(COL_FLOOR);
  localparam logic [WW-1:0]  RMIN = WW'(ROW_FLOOR);
  localparam logic [BKW-1:0] BK8  = BKW'(3);
  localparam logic [BKW-1:0] BK4  = BKW'(2);

  sq_state_t      st_q, st_d;
  logic [WW-1:0]  cur_q, cur_d, col_q, col_d, row_q, row_d, lcol_q, lcol_d, lrow_q, lrow_d;
  logic [BKW-1:0] bank_q, bank_d, lbank_q, lbank_d;
  logic [2:0]     type_q, type_d;
  logic           pend_q, pend_d;
  logic           fixed_bank;

  assign fixed_bank = (type_q == TYPE_FIXED_8BANK);

  always_comb begin
    go = ((st_q == SQ_COL) || (st_q == SQ_ROW) ||
          ((st_q == SQ_BANK) && !fixed_bank)) && !pend_q;
    case (st_q)
      SQ_BANK: exp_o = EW'(lbank_q) + EW'(lcol_q) + EW'(BW) - EW'(1);
      SQ_ROW:  exp_o = EW'(cur_q) + EW'(lbank_q) + EW'(lcol_q) + EW'(BW) - EW'(1);
      default: exp_o = EW'(cur_q) + EW'(BW) - EW'(1);
    endcase
  end

  always_comb begin
    st_d = st_q; cur_d = cur_q; col_d = col_q; row_d = row_q; bank_d = bank_q;
    lcol_d = lcol_q; lrow_d = lrow_q; lbank_d = lbank_q; type_d = type_q;
    pend_d = pend_q;
    if (go) pend_d = 1'b1;
    if (fin) pend_d = 1'b0;
    case (st_q)
      SQ_COL: if (fin) begin
        if (pass) begin
          col_d = cur_q;
          st_d  = SQ_BANK;
        end else if (cur_q == CMIN) st_d = SQ_FAIL;
        else cur_d = cur_q - WW'(1);
      end
      SQ_BANK: begin
        if (fixed_bank || fin) begin
          bank_d = (fixed_bank || pass) ? BK8 : BK4;
          cur_d  = lrow_q;
          st_d   = (lrow_q < RMIN) ? SQ_FAIL : SQ_ROW;
        end
      end
      SQ_ROW: if (fin) begin
        if (pass) begin
          row_d = cur_q;
          st_d  = SQ_DONE;
        end else if (cur_q == RMIN) st_d = SQ_FAIL;
        else cur_d = cur_q - WW'(1);
      end
      default: if (start) begin
        lcol_d  = col_max;
        lbank_d = bank_max;
        lrow_d  = row_max;
        type_d  = mem_type;
        cur_d   = col_max;
        col_d   = '0;
        row_d   = '0;
        bank_d  = '0;
        pend_d  = 1'b0;
        st_d    = (col_max < CMIN) ? SQ_FAIL : SQ_COL;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; cur_q <= '0; col_q <= '0; row_q <= '0; bank_q <= '0;
      lcol_q <= '0; lrow_q <= '0; lbank_q <= '0; type_q <= '0; pend_q <= 1'b0;
    end else begin
      st_q <= st_d; cur_q <= cur_d; col_q <= col_d; row_q <= row_d; bank_q <= bank_d;
      lcol_q <= lcol_d; lrow_q <= lrow_d; lbank_q <= lbank_d; type_q <= type_d;
      pend_q <= pend_d;
    end
  end

  assign busy   = (st_q == SQ_COL) || (st_q == SQ_BANK) || (st_q == SQ_ROW);
  assign done   = (st_q == SQ_DONE);
  assign fail   = (st_q == SQ_FAIL);
  assign col_w  = col_q;
  assign bank_w = bank_q;
  assign row_w  = row_q;
  assign type_o = type_q;
endmodule

// File: rtl/geom_encode.sv
module geom_encode #(
  parameter int WW  = 5,
  parameter int BKW = 2,
  parameter int BW  = 1,
  parameter int SZW = 7,
  parameter int STW = 16
) (
  input  logic           done,
  input  logic [WW-1:0]  col_w,
  input  logic [BKW-1:0] bank_w,
  input  logic [WW-1:0]  row_w,
  input  logic [2:0]     type_i,
  output logic [SZW-1:0] size_log2,
  output logic [STW-1:0] status,
  output logic           row12
);
  always_comb begin
    size_log2 = '0;
    status    = '0;
    row12     = 1'b0;
    if (done) begin
      size_log2   = SZW'(BW) + SZW'(col_w) + SZW'(row_w) + SZW'(bank_w);
      status[3:0] = 4'(col_w - WW'(9));
      status[4]   = (bank_w == BKW'(2));
      status[8:5] = 4'(row_w - WW'(13));
      status[11:9] = type_i;
      row12       = (row_w == WW'(12));
    end
  end
endmodule

// File: rtl/geom_probe.sv
module geom_probe #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int WW  = 5,
  parameter int BKW = 2,
  parameter int BW  = 1,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [DW-1:0] PATTERN = 32'h5AA5_C33C
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     mem_type,
  input  logic [WW-1:0]  col_max,
  input  logic [BKW-1:0] bank_max,
  input  logic [WW-1:0]  row_max,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [WW-1:0]  col_w,
  output logic [BKW-1:0] bank_w,
  output logic [WW-1:0]  row_w,
  output logic [6:0]     size_log2,
  output logic [15:0]    status,
  output logic           row12,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata
);
  localparam int EW = $clog2(AW) + 1;

  logic          rst_i_n;
  logic          go, fin, pass;
  logic [EW-1:0] exp_w;
  logic [2:0]    type_w;

  geom_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  geom_seq #(.WW(WW), .BKW(BKW), .EW(EW), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(start), .mem_type(mem_type),
    .col_max(col_max), .bank_max(bank_max), .row_max(row_max),
    .fin(fin), .pass(pass), .go(go), .exp_o(exp_w),
    .busy(busy), .done(done), .fail(err),
    .col_w(col_w), .bank_w(bank_w), .row_w(row_w), .type_o(type_w)
  );

  geom_access #(.AW(AW), .DW(DW), .EW(EW), .BASE(BASE), .PATTERN(PATTERN)) u_acc (
    .clk(clk), .rst_n(rst_i_n), .go(go), .exp_i(exp_w), .fin(fin), .pass(pass),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  geom_encode #(.WW(WW), .BKW(BKW), .BW(BW), .SZW(7), .STW(16)) u_enc (
    .done(done), .col_w(col_w), .bank_w(bank_w), .row_w(row_w), .type_i(type_w),
    .size_log2(size_log2), .status(status), .row12(row12)
  );
endmodule

// File: rtl/geom_probe_chk.sv
module geom_probe_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int WW  = 5,
  parameter int BKW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic [WW-1:0]  col_w,
  input logic [BKW-1:0] bank_w,
  input logic [WW-1:0]  row_w,
  input logic [15:0]    status,
  input logic           row12,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({busy, done, err}) <= 1);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  assert_busy_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_width_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (col_w >= WW'(10)) && (row_w >= WW'(12)) && (bank_w >= BKW'(2)));

  assert_row12_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    row12 |-> done && (row_w == WW'(12)));

  assert_status_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[15:12] == 4'd0);
endmodule

bind geom_probe geom_probe_chk #(.AW(AW), .DW(DW), .WW(WW), .BKW(BKW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .col_w(col_w), .bank_w(bank_w), .row_w(row_w), .status(status), .row12(row12),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/sim_geom_probe.sv
`timescale 1ns/1ps
module sim_geom_probe;
  localparam logic [31:0] PAT = 32'h5AA5_C33C;

  logic        clk, rst_n, start;
  logic [2:0]  mem_type;
  logic [4:0]  col_max, row_max, col_w, row_w;
  logic [1:0]  bank_max, bank_w;
  logic        busy, done, err, row12;
  logic [6:0]  size_log2;
  logic [15:0] status;
  logic        mem_valid, mem_ready, mem_we, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_tests = 0, n_fail = 0;
  int g_col, g_bank, g_row, m_col, m_bank;
  int acc_cnt, cyc;
  logic [31:0] tr_addr [0:63];
  logic [31:0] tr_data [0:63];
  logic        tr_we   [0:63];
  logic [31:0] mem [longint];

  geom_probe u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_type(mem_type),
    .col_max(col_max), .bank_max(bank_max), .row_max(row_max),
    .busy(busy), .done(done), .err(err), .col_w(col_w), .bank_w(bank_w),
    .row_w(row_w), .size_log2(size_log2), .status(status), .row12(row12),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic longint mkey(logic [31:0] a);
    longint la, c, b, r;
    la = longint'(a);
    c = (la >> 1) & ((longint'(1) << m_col) - 1) & ((longint'(1) << g_col) - 1);
    b = (la >> (1 + m_col)) & ((longint'(1) << m_bank) - 1) & ((longint'(1) << g_bank) - 1);
    r = (la >> (1 + m_col + m_bank)) & ((longint'(1) << g_row) - 1);
    return (r << 24) | (b << 20) | c;
  endfunction

  // memory model: stalls one cycle in three, read data one cycle after acceptance
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ready  <= rst_n && ((cyc % 3) != 2);
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (acc_cnt < 64) begin
        tr_addr[acc_cnt] = mem_addr; tr_data[acc_cnt] = mem_wdata; tr_we[acc_cnt] = mem_we;
      end
      acc_cnt = acc_cnt + 1;
      if (mem_we) mem[mkey(mem_addr)] = mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem.exists(mkey(mem_addr)) ? mem[mkey(mem_addr)] : 32'hDEAD_BEEF;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic setup(int typ, int cm, int bm, int rm, int gc, int gb, int gr);
    mem_type = 3'(typ); col_max = 5'(cm); bank_max = 2'(bm); row_max = 5'(rm);
    m_col = cm; m_bank = bm; g_col = gc; g_bank = gb; g_row = gr;
    mem.delete();
    acc_cnt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || err) && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done/err", {30'd0, done, err}, 0);
    chk("R1 mem_valid", 32'(mem_valid), 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 row12/size", {24'd0, row12, size_log2}, 0);
  endtask

  task automatic t_fold_col();
    setup(2, 11, 3, 15, 10, 2, 13);
    pulse_start();
    chk("R11 busy after start", 32'(busy), 1);
    wait_end();
    chk("R2 acc0 write zero base", {tr_we[0], tr_addr[0], tr_data[0]} , {1'b1, 32'h0, 32'h0});
    chk("R2 acc1 pattern at 2^11", {tr_we[1], tr_addr[1], tr_data[1]} , {1'b1, 32'h800, PAT});
    chk("R2 acc2 read offset", {tr_we[2], tr_addr[2]}, {1'b0, 32'h800});
    chk("R2 acc3 read base", {tr_we[3], tr_addr[3]}, {1'b0, 32'h0});
    chk("R3 col", 32'(col_w), 10);
    chk("R5 bank probe fail gives 2", 32'(bank_w), 2);
    chk("R5 bank probe addr 2^14", tr_addr[9], 32'h4000);
    chk("R6 row", 32'(row_w), 13);
    chk("R6 accesses", 32'(acc_cnt), 24);
    chk("R8 size", 32'(size_log2), 26);
    chk("R9 status", 32'(status), 32'h411);
    chk("R11 done not busy", {30'd0, busy, done}, 1);
    chk("R10 row12 low", 32'(row12), 0);
  endtask

  task automatic t_fixed_bank();
    setup(3, 10, 3, 16, 10, 2, 16);
    pulse_start(); wait_end();
    chk("R5 fixed bank", 32'(bank_w), 3);
    chk("R5 no bank probe", 32'(acc_cnt), 8);
    chk("R6 row max first", 32'(row_w), 16);
    chk("R8 size", 32'(size_log2), 30);
    chk("R9 status", 32'(status), 32'h661);
  endtask

  task automatic t_row12();
    setup(5, 12, 3, 14, 12, 3, 12);
    pulse_start(); wait_end();
    chk("R5 bank probe pass", 32'(bank_w), 3);
    chk("R6 row floor", 32'(row_w), 12);
    chk("R10 row12 high", 32'(row12), 1);
    chk("R9 status wrap", 32'(status), 32'hBE3);
    chk("R8 size", 32'(size_log2), 28);
    chk("R6 accesses", 32'(acc_cnt), 20);
  endtask

  task automatic t_col_err();
    setup(2, 11, 3, 15, 9, 3, 15);
    pulse_start(); wait_end();
    chk("R4 err", {30'd0, err, done}, 2);
    chk("R4 stops at floor", 32'(acc_cnt), 8);
    chk("R9 status zero", 32'(status), 0);
    setup(2, 9, 3, 15, 9, 3, 15);
    pulse_start(); repeat (4) @(negedge clk);
    chk("R4 small col_max err", 32'(err), 1);
    chk("R4 small col_max no access", 32'(acc_cnt), 0);
  endtask

  task automatic t_row_err();
    setup(3, 10, 3, 13, 10, 3, 11);
    pulse_start(); wait_end();
    chk("R7 err", {30'd0, err, done}, 2);
    chk("R7 accesses", 32'(acc_cnt), 12);
    chk("R11 idle after err", 32'(busy), 0);
  endtask

  task automatic t_restart_hold();
    setup(2, 11, 3, 15, 10, 2, 13);
    pulse_start();
    repeat (5) @(negedge clk);
    mem_type = 3'd3; col_max = 5'd12; row_max = 5'd16;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end();
    chk("R11 restart ignored col", 32'(col_w), 10);
    chk("R11 restart ignored bank", 32'(bank_w), 2);
    chk("R11 restart ignored status", 32'(status), 32'h411);
    repeat (20) @(negedge clk);
    chk("R12 hold", {16'd0, done, err, busy, col_w, row_w, 1'b0, bank_w}, {16'd0, 1'b1, 1'b0, 1'b0, 5'd10, 5'd13, 1'b0, 2'd2});
    chk("R12 no traffic", 32'(acc_cnt), 24);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc = 0; acc_cnt = 0; mem_rdata = '0; mem_ready = 1'b0; mem_rvalid = 1'b0;
    rst_n = 1'b0; start = 1'b0;
    mem_type = '0; col_max = '0; bank_max = '0; row_max = '0;
    m_col = 10; m_bank = 3; g_col = 10; g_bank = 3; g_row = 13;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fold_col();
    t_fixed_bank();
    t_row12();
    t_col_err();
    t_row_err();
    t_restart_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule